// File: doc/BRIEF.md
# Framebuffer Span Copy Engine

This block carries out one span-copy command that already sits in a command buffer. After a start pulse it reads the command words through a word-addressed read port with one cycle of latency. It first checks the opcode word and takes the span count from the count word. Then, one span at a time, it reads a three-word descriptor and copies a run of pixels from the start of a source scanline to the start of a destination scanline. The framebuffer is 1280 pixels wide and is reached through a single synchronous read/write port.

Length and row words arrive scaled up by eight, and the engine scales them back down before use. If the buffer holds fewer words than the command needs, the engine asks its fetch logic to refill the buffer and waits for it. The engine keeps a dirty rectangle that a display refresh path can use to limit redraw. It reports busy while it works and gives a one-cycle done pulse at the end.

Top module: `span_copy_engine`

## Requirements
- R1: A command runs only when command word 0 equals 0x00000405 exactly. Any other value gives a done pulse with no framebuffer write, no refetch request and no change to the dirty outputs.
- R2: The span count is bits 31:24 of command word 1. The other 24 bits of that word have no effect.
- R3: Span k is described by command words 5+3k, 6+3k and 7+3k, holding the length, the source row and the destination row, in that order.
- R4: The length, source and destination words are each shifted right by 3 before use. Their low 3 bits have no effect. A row is the low 10 bits of the shifted value.
- R5: A shifted length greater than 1280 is treated as 1280.
- R6: Each span copies pixels for columns 0 up to length-1, in rising column order. Each pixel at framebuffer address src*1280+col is read before it is written to address dst*1280+col. Spans run strictly in command order, so a later span sees the writes of an earlier one, and a span whose source and destination rows are equal leaves its row unchanged.
- R7: After reset, the dirty outputs are x_lo=0, x_hi=0, y_lo=1023 and y_hi=0. Each executed span sets x_lo=0 and x_hi=1279, and widens y_lo and y_hi to include both its source row and its destination row.
- R8: A command needs 5+3*count words. When cmd_words is smaller than that, the engine gives a one-cycle refetch pulse with refetch_words equal to the needed word count. It then reads no descriptor and touches no framebuffer location until refetch_done.
- R9: start is ignored while busy is high. Each command ends with exactly one done pulse of one cycle, after the last pixel write. A span count of 0 gives done with no write and no refetch.
- R10: After reset, busy and done are low and the engine drives no framebuffer or command-buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the buffered command (sampled only when idle) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| cmd_re | output | 1 | Command buffer read enable |
| cmd_addr | output | 10 | Command buffer word address |
| cmd_rdata | input | 32 | Command word, valid the cycle after cmd_re |
| cmd_words | input | 11 | Number of valid words in the command buffer |
| refetch | output | 1 | One-cycle request to refill the command buffer |
| refetch_words | output | 11 | Word count the refill must supply |
| refetch_done | input | 1 | Refill finished |
| fb_re | output | 1 | Framebuffer read enable |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 21 | Framebuffer pixel address, row*1280+column |
| fb_wdata | output | 8 | Pixel write data |
| fb_rdata | input | 8 | Pixel read data, valid the cycle after fb_re |
| dirty_x_lo | output | 11 | Dirty rectangle left column |
| dirty_x_hi | output | 11 | Dirty rectangle right column |
| dirty_y_lo | output | 10 | Dirty rectangle top row |
| dirty_y_hi | output | 10 | Dirty rectangle bottom row |

## Verification
The overlap that matters is a new start arriving while the previous command is ending. The bench holds start high for a whole command, including the cycle in which done pulses, and releases it only once done is seen. A second run of the command would then show up as extra pixel writes against the reference queue and as a second done pulse. Another overlap sits inside the one framebuffer port. A span whose source equals its destination, and a span that reads the row an earlier span just wrote, both pass only if every write carries the value read in the cycle before it. The reference model checks each write on the clock it appears.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam logic [31:0] OPC_SPAN_COPY = 32'h0000_0405;
    localparam int          HDR_WORDS     = 5;
    localparam int          DESC_WORDS    = 3;
    localparam int          SCALE_SH      = 3;
    localparam int          SPAN_FW       = 16;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RD_OP,
        SQ_GET_OP,
        SQ_RD_CNT,
        SQ_GET_CNT,
        SQ_REFETCH,
        SQ_WAIT_F,
        SQ_RD_W,
        SQ_GET_W,
        SQ_LAUNCH,
        SQ_WAIT_C,
        SQ_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_RD,
        CP_WR,
        CP_FIN
    } cp_state_t;

    typedef struct packed {
        logic [SPAN_FW-1:0] len;
        logic [SPAN_FW-1:0] src;
        logic [SPAN_FW-1:0] dst;
    } span_t;

    function automatic logic [31-SCALE_SH:0] descale(input logic [31:0] w);
        return w[31:SCALE_SH];
    endfunction

    function automatic logic [SPAN_FW-1:0] clamp_len(input logic [31-SCALE_SH:0] v,
                                                      input int lim);
        if (v > (32-SCALE_SH)'(lim))
            return SPAN_FW'(lim);
        return v[SPAN_FW-1:0];
    endfunction

endpackage

// File: rtl/spx_cmd_seq.sv
module spx_cmd_seq
    import spx_pkg::*;
#(
    parameter int WIDTH  = 1280,
    parameter int ROW_W  = 10,
    parameter int CMD_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cmd_re,
    output logic [CMD_AW-1:0] cmd_addr,
    input  logic [31:0]       cmd_rdata,
    input  logic [CMD_AW:0]   cmd_words,
    output logic              refetch,
    output logic [CMD_AW:0]   refetch_words,
    input  logic              refetch_done,
    output logic              span_go,
    output span_t             span_o,
    input  logic              copy_fin,
    output logic              busy,
    output logic              done
);
    localparam int NW = CMD_AW + 1;

    seq_state_t        state;
    logic [7:0]        n_left;
    logic [CMD_AW-1:0] ptr;
    logic [1:0]        fld;
    logic [NW-1:0]     need_q;
    span_t             span_q;

    logic [31-SCALE_SH:0] scaled;
    logic [NW-1:0]        need_c;
    logic [SPAN_FW-1:0]   row_c;

    assign scaled = descale(cmd_rdata);
    assign row_c  = SPAN_FW'(scaled[ROW_W-1:0]);
    assign need_c = NW'(HDR_WORDS) + NW'(DESC_WORDS) * NW'(cmd_rdata[31:24]);

    always_comb begin
        cmd_re   = (state == SQ_RD_OP) || (state == SQ_RD_CNT) || (state == SQ_RD_W);
        cmd_addr = ptr;
        if (state == SQ_RD_OP)
            cmd_addr = '0;
        else if (state == SQ_RD_CNT)
            cmd_addr = CMD_AW'(1);
    end

    assign refetch       = (state == SQ_REFETCH);
    assign refetch_words = need_q;
    assign span_go       = (state == SQ_LAUNCH);
    assign span_o        = span_q;
    assign busy          = (state != SQ_IDLE);
    assign done          = (state == SQ_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            n_left <= '0;
            ptr    <= '0;
            fld    <= '0;
            need_q <= '0;
            span_q <= '0;
        end else begin
            unique case (state)
                SQ_IDLE:    if (start) state <= SQ_RD_OP;
                SQ_RD_OP:   state <= SQ_GET_OP;
                SQ_GET_OP:  state <= (cmd_rdata == OPC_SPAN_COPY) ? SQ_RD_CNT : SQ_FIN;
                SQ_RD_CNT:  state <= SQ_GET_CNT;
                SQ_GET_CNT: begin
                    n_left <= cmd_rdata[31:24];
                    need_q <= need_c;
                    ptr    <= CMD_AW'(HDR_WORDS);
                    fld    <= '0;
                    if (cmd_rdata[31:24] == 8'd0)
                        state <= SQ_FIN;
                    else if (need_c > cmd_words)
                        state <= SQ_REFETCH;
                    else
                        state <= SQ_RD_W;
                end
                SQ_REFETCH: state <= SQ_WAIT_F;
                SQ_WAIT_F:  if (refetch_done) state <= SQ_RD_W;
                SQ_RD_W:    state <= SQ_GET_W;
                SQ_GET_W: begin
                    ptr <= ptr + CMD_AW'(1);
                    unique case (fld)
                        2'd0:    span_q.len <= clamp_len(scaled, WIDTH);
                        2'd1:    span_q.src <= row_c;
                        default: span_q.dst <= row_c;
                    endcase
                    if (fld == 2'd2) begin
                        fld   <= '0;
                        state <= SQ_LAUNCH;
                    end else begin
                        fld   <= fld + 2'd1;
                        state <= SQ_RD_W;
                    end
                end
                SQ_LAUNCH:  state <= SQ_WAIT_C;
                SQ_WAIT_C: begin
                    if (copy_fin) begin
                        if (n_left == 8'd1) begin
                            state <= SQ_FIN;
                        end else begin
                            n_left <= n_left - 8'd1;
                            state  <= SQ_RD_W;
                        end
                    end
                end
                SQ_FIN:     state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spx_row_copy.sv
module spx_row_copy
    import spx_pkg::*;
#(
    parameter int WIDTH  = 1280,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  span_t             span_i,
    output logic              fb_re,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [PIX_W-1:0]  fb_wdata,
    input  logic [PIX_W-1:0]  fb_rdata,
    output logic              fin
);
    cp_state_t          st;
    span_t              sp;
    logic [SPAN_FW-1:0] col;
    logic [ADDR_W-1:0]  src_base;
    logic [ADDR_W-1:0]  dst_base;

    assign src_base = ADDR_W'(sp.src) * ADDR_W'(WIDTH);
    assign dst_base = ADDR_W'(sp.dst) * ADDR_W'(WIDTH);

    assign fb_re    = (st == CP_RD);
    assign fb_we    = (st == CP_WR);
    assign fb_addr  = ((st == CP_WR) ? dst_base : src_base) + ADDR_W'(col);
    assign fb_wdata = fb_rdata;
    assign fin      = (st == CP_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CP_IDLE;
            sp  <= '0;
            col <= '0;
        end else begin
            unique case (st)
                CP_IDLE: begin
                    if (go) begin
                        sp  <= span_i;
                        col <= '0;
                        st  <= (span_i.len == '0) ? CP_FIN : CP_RD;
                    end
                end
                CP_RD:   st <= CP_WR;
                CP_WR: begin
                    col <= col + SPAN_FW'(1);
                    st  <= (col + SPAN_FW'(1) == sp.len) ? CP_FIN : CP_RD;
                end
                default: st <= CP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spx_dirty_track.sv
module spx_dirty_track
    import spx_pkg::*;
#(
    parameter int WIDTH = 1280,
    parameter int ROW_W = 10,
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  span_t            span_i,
    output logic [COL_W-1:0] x_lo,
    output logic [COL_W-1:0] x_hi,
    output logic [ROW_W-1:0] y_lo,
    output logic [ROW_W-1:0] y_hi
);
    logic [ROW_W-1:0] r_a;
    logic [ROW_W-1:0] r_b;
    logic [ROW_W-1:0] mn;
    logic [ROW_W-1:0] mx;

    assign r_a = span_i.src[ROW_W-1:0];
    assign r_b = span_i.dst[ROW_W-1:0];

    always_comb begin
        mn = y_lo;
        mx = y_hi;
        if (r_a < mn) mn = r_a;
        if (r_b < mn) mn = r_b;
        if (r_a > mx) mx = r_a;
        if (r_b > mx) mx = r_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_lo <= '0;
            x_hi <= '0;
            y_lo <= '1;
            y_hi <= '0;
        end else if (upd) begin
            x_lo <= '0;
            x_hi <= COL_W'(WIDTH - 1);
            y_lo <= mn;
            y_hi <= mx;
        end
    end

endmodule

// File: rtl/span_copy_engine.sv
module span_copy_engine
    import spx_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int WIDTH  = 1280,
    parameter int ROW_W  = 10,
    parameter int CMD_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              cmd_re,
    output logic [CMD_AW-1:0] cmd_addr,
    input  logic [31:0]       cmd_rdata,
    input  logic [CMD_AW:0]   cmd_words,
    output logic              refetch,
    output logic [CMD_AW:0]   refetch_words,
    input  logic              refetch_done,
    output logic              fb_re,
    output logic              fb_we,
    output logic [$clog2(WIDTH*(2**ROW_W))-1:0] fb_addr,
    output logic [PIX_W-1:0]  fb_wdata,
    input  logic [PIX_W-1:0]  fb_rdata,
    output logic [$clog2(WIDTH)-1:0] dirty_x_lo,
    output logic [$clog2(WIDTH)-1:0] dirty_x_hi,
    output logic [ROW_W-1:0]  dirty_y_lo,
    output logic [ROW_W-1:0]  dirty_y_hi
);
    localparam int COL_W  = $clog2(WIDTH);
    localparam int ADDR_W = $clog2(WIDTH * (2**ROW_W));

    logic  span_go;
    logic  copy_fin;
    span_t span_w;

    spx_cmd_seq #(.WIDTH(WIDTH), .ROW_W(ROW_W), .CMD_AW(CMD_AW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .cmd_re(cmd_re), .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata),
        .cmd_words(cmd_words), .refetch(refetch), .refetch_words(refetch_words),
        .refetch_done(refetch_done), .span_go(span_go), .span_o(span_w),
        .copy_fin(copy_fin), .busy(busy), .done(done)
    );

    spx_row_copy #(.WIDTH(WIDTH), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_copy (
        .clk(clk), .rst(rst), .go(span_go), .span_i(span_w),
        .fb_re(fb_re), .fb_we(fb_we), .fb_addr(fb_addr),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata), .fin(copy_fin)
    );

    spx_dirty_track #(.WIDTH(WIDTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_dirty (
        .clk(clk), .rst(rst), .upd(span_go), .span_i(span_w),
        .x_lo(dirty_x_lo), .x_hi(dirty_x_hi),
        .y_lo(dirty_y_lo), .y_hi(dirty_y_hi)
    );

endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
    parameter int FB_WORDS = 1310720,
    parameter int ADDR_W   = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cmd_re,
    input logic              refetch,
    input logic              fb_re,
    input logic              fb_we,
    input logic [ADDR_W-1:0] fb_addr
);
    // R6: one framebuffer operation per cycle on the shared port
    a_r6_one_port_op: assert property (@(posedge clk) disable iff (rst)
        !(fb_re && fb_we));

    // R6: every access lands inside the framebuffer
    a_r6_addr_range: assert property (@(posedge clk) disable iff (rst)
        (fb_re || fb_we) |-> (32'(fb_addr) < FB_WORDS));

    // R9: done lasts exactly one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the engine is idle after done
    a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10: no access of any kind while idle
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fb_we && !fb_re && !cmd_re && !refetch));

    // R8: refetch is a single-cycle request
    a_r8_refetch_pulse: assert property (@(posedge clk) disable iff (rst)
        refetch |=> !refetch);

endmodule

bind span_copy_engine spx_checker #(
    .FB_WORDS(WIDTH * (2**ROW_W)),
    .ADDR_W($clog2(WIDTH * (2**ROW_W)))
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .cmd_re(cmd_re),
    .refetch(refetch), .fb_re(fb_re), .fb_we(fb_we), .fb_addr(fb_addr)
);

// File: tb/span_copy_engine_tb.sv
module span_copy_engine_tb;
    localparam int W = 1280;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic        busy, done, cmd_re, refetch, refetch_done = 0;
    logic [9:0]  cmd_addr;
    logic [31:0] cmd_rdata = '0;
    logic [10:0] cmd_words = '0;
    logic [10:0] refetch_words;
    logic        fb_re, fb_we;
    logic [20:0] fb_addr;
    logic [7:0]  fb_wdata;
    logic [7:0]  fb_rdata = '0;
    logic [10:0] dx_lo, dx_hi;
    logic [9:0]  dy_lo, dy_hi;

    always #4 clk = ~clk;

    span_copy_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .cmd_re(cmd_re), .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata),
        .cmd_words(cmd_words), .refetch(refetch), .refetch_words(refetch_words),
        .refetch_done(refetch_done), .fb_re(fb_re), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
        .dirty_x_lo(dx_lo), .dirty_x_hi(dx_hi), .dirty_y_lo(dy_lo), .dirty_y_hi(dy_hi)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memories
    logic [31:0] cmdm [0:1023];
    logic [7:0]  fbm [int];
    logic [7:0]  sh  [int];

    function automatic logic [7:0] pix0(input int a);
        return 8'((a * 7) + (a >>> 11) + 3);
    endfunction

    always @(posedge clk) begin
        if (cmd_re) cmd_rdata <= cmdm[cmd_addr];
        if (fb_re) fb_rdata <= fbm.exists(int'(fb_addr)) ? fbm[int'(fb_addr)] : pix0(int'(fb_addr));
        if (fb_we) fbm[int'(fb_addr)] = fb_wdata;
    end

    // reference write stream
    int q_addr[$];
    int q_data[$];
    int wr_cnt = 0;
    int done_cnt = 0;
    int rf_seen = 0;
    int rf_len = 0;
    int rf_wait = 0;
    bit rf_hold = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (fb_we) begin
                wr_cnt++;
                if (q_addr.size() == 0) begin
                    chk(0, "R6", "unexpected pixel write addr", int'(fb_addr), -1);
                end else begin
                    int ea, ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    chk(int'(fb_addr) == ea, "R6", "write address", int'(fb_addr), ea);
                    chk(int'(fb_wdata) == ed, "R6", "write data", int'(fb_wdata), ed);
                end
            end
            refetch_done = 0;
            if (rf_hold && (fb_re || fb_we || cmd_re))
                chk(0, "R8", "access during refill wait", 1, 0);
            if (refetch) begin
                rf_seen++;
                rf_len  = int'(refetch_words);
                rf_wait = 6;
                rf_hold = 1;
            end else if (rf_wait > 0) begin
                rf_wait--;
                if (rf_wait == 0) begin
                    refetch_done = 1;
                    rf_hold = 0;
                end
            end
        end
    end

    // expected dirty state
    int ex_lo = 0, ex_hi = 0, ey_lo = 1023, ey_hi = 0;
    logic [31:0] dl [0:7];
    logic [31:0] ds [0:7];
    logic [31:0] dd [0:7];

    task automatic run_cmd(input logic [31:0] op, input logic [31:0] cntw, input int nsp,
                           input int avail, input bit hold, input string tag,
                           input int exp_writes_req, input string wreq);
        int need, exp_w, d0, tmo;
        need = 5 + 3 * nsp;
        exp_w = 0;
        for (int i = 0; i < 1024; i++) cmdm[i] = 32'hDEAD_0000 + 32'(i);
        cmdm[0] = op;
        cmdm[1] = cntw;
        for (int k = 0; k < nsp; k++) begin
            cmdm[5 + 3*k] = dl[k];
            cmdm[6 + 3*k] = ds[k];
            cmdm[7 + 3*k] = dd[k];
        end
        if (op == 32'h405) begin
            for (int k = 0; k < nsp; k++) begin
                int L, s, d;
                L = int'(dl[k] >> 3);
                if (L > W) L = W;
                s = int'((ds[k] >> 3) & 32'h3ff);
                d = int'((dd[k] >> 3) & 32'h3ff);
                ex_lo = 0; ex_hi = W - 1;
                if (s < ey_lo) ey_lo = s;
                if (d < ey_lo) ey_lo = d;
                if (s > ey_hi) ey_hi = s;
                if (d > ey_hi) ey_hi = d;
                for (int c = 0; c < L; c++) begin
                    int sa, da;
                    logic [7:0] v;
                    sa = s * W + c;
                    da = d * W + c;
                    v = sh.exists(sa) ? sh[sa] : pix0(sa);
                    q_addr.push_back(da);
                    q_data.push_back(int'(v));
                    sh[da] = v;
                    exp_w++;
                end
            end
        end
        @(negedge clk);
        cmd_words = 11'(avail);
        wr_cnt = 0;
        rf_seen = 0;
        d0 = done_cnt;
        start = 1;
        if (!hold) begin
            @(negedge clk);
            start = 0;
        end
        tmo = 0;
        while (!done && tmo < 20000) begin
            @(negedge clk);
            tmo++;
        end
        start = 0;
        repeat (4) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9", {tag, " done pulses"}, done_cnt - d0, 1);
        chk(!busy, "R9", {tag, " idle after done"}, int'(busy), 0);
        chk(wr_cnt == exp_w, wreq, {tag, " write count"}, wr_cnt, exp_w);
        if (exp_writes_req >= 0)
            chk(wr_cnt == exp_writes_req, wreq, {tag, " write count fixed"}, wr_cnt, exp_writes_req);
        chk(q_addr.size() == 0, "R6", {tag, " pending writes"}, q_addr.size(), 0);
        if (op == 32'h405 && nsp > 0 && need > avail) begin
            chk(rf_seen == 1, "R8", {tag, " refetch count"}, rf_seen, 1);
            chk(rf_len == need, "R8", {tag, " refetch words"}, rf_len, need);
        end else begin
            chk(rf_seen == 0, "R8", {tag, " no refetch"}, rf_seen, 0);
        end
        chk(int'(dx_lo) == ex_lo, "R7", {tag, " x_lo"}, int'(dx_lo), ex_lo);
        chk(int'(dx_hi) == ex_hi, "R7", {tag, " x_hi"}, int'(dx_hi), ex_hi);
        chk(int'(dy_lo) == ey_lo, "R7", {tag, " y_lo"}, int'(dy_lo), ey_lo);
        chk(int'(dy_hi) == ey_hi, "R7", {tag, " y_hi"}, int'(dy_hi), ey_hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) cmdm[i] = '0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state, R7 reset dirty
        chk(!busy && !done, "R10", "busy/done after reset", int'(busy) + int'(done), 0);
        chk(!fb_we && !fb_re && !cmd_re, "R10", "no access after reset", int'(fb_we), 0);
        chk(dy_lo == 10'h3ff && dy_hi == 0, "R7", "reset y range", int'(dy_lo), 1023);
        chk(dx_lo == 0 && dx_hi == 0, "R7", "reset x range", int'(dx_hi), 0);

        // R1: wrong opcode, near miss
        dl[0] = 32'd128; ds[0] = 32'd8; dd[0] = 32'd16;
        run_cmd(32'h0000_0404, 32'h0100_0000, 1, 100, 0, "R1 opcode 0x404", 0, "R1");
        run_cmd(32'h1000_0405, 32'h0100_0000, 1, 100, 0, "R1 opcode high bits", 0, "R1");

        // R9: zero spans
        run_cmd(32'h405, 32'h00FF_FFFF, 0, 5, 0, "R9 zero spans", 0, "R9");

        // R2, R3, R4: one span, garbage in low bits of count and descriptors
        dl[0] = (32'd16 << 3) | 32'd7;
        ds[0] = (32'd3 << 3) | 32'd5;
        dd[0] = (32'd10 << 3) | 32'd6;
        run_cmd(32'h405, 32'h01AB_CDEF, 1, 100, 0, "R2 R3 R4 single span", 16, "R4");

        // R6: ordered spans, chained rows, same-row span, zero length
        dl[0] = 32'd20 << 3; ds[0] = 32'd40 << 3;  dd[0] = 32'd41 << 3;
        dl[1] = 32'd12 << 3; ds[1] = 32'd41 << 3;  dd[1] = 32'd2 << 3;
        dl[2] = 32'd9 << 3;  ds[2] = 32'd7 << 3;   dd[2] = 32'd7 << 3;
        dl[3] = 32'd0;       ds[3] = 32'd900 << 3; dd[3] = 32'd901 << 3;
        run_cmd(32'h405, 32'h0400_0000, 4, 100, 0, "R6 ordered spans", 41, "R6");

        // R5: clamp
        dl[0] = 32'd3000 << 3; ds[0] = 32'd100 << 3; dd[0] = 32'd200 << 3;
        run_cmd(32'h405, 32'h0100_0000, 1, 100, 0, "R5 clamp", 1280, "R5");

        // R8: short buffer triggers refill
        dl[0] = 32'd5 << 3; ds[0] = 32'd11 << 3; dd[0] = 32'd12 << 3;
        dl[1] = 32'd6 << 3; ds[1] = 32'd12 << 3; dd[1] = 32'd13 << 3;
        run_cmd(32'h405, 32'h0200_0000, 2, 5, 0, "R8 refill", 11, "R8");

        // R9: start held through the whole command including done
        dl[0] = 32'd8 << 3; ds[0] = 32'd50 << 3; dd[0] = 32'd51 << 3;
        run_cmd(32'h405, 32'h0100_0000, 1, 100, 1, "R9 held start", 8, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule